// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for the master side of an I2C bus. A 7-bit down-counter, loaded from a reload input, sets the length of each SCL phase. Each time the counter runs out, the block changes how it drives SCL. The drive is open-drain: the block either pulls the line low or lets it float.

After the block lets SCL go, the counter stays frozen until the line is actually seen high. A slave that holds SCL low therefore stretches the low phase, and the high phase that follows still gets its full count. The SCL pin is sampled through a two-stage synchronizer.

A one-cycle strobe marks every expiry of the counter. A byte-level sequencer can use it to place SDA changes. Start, stop, shifting and SDA handling belong to that sequencer.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, and while `en` is low, `scl_drive_low` is 0 and `roll_stb` is 0, whatever `scl_in` does.
- R2: With reload value N (1..127), each low phase lasts exactly 2N clock cycles, because the counter steps once every two cycles.
- R3: After the block releases SCL, counting pauses until `scl_in` has passed two synchronizer flops and is seen high. The counter then reloads and counts N steps, so an unstretched high phase on the line lasts exactly 2N+2 cycles.
- R4: If a slave holds SCL low for H extra cycles after the release, the line stays low for 2N+H cycles in total. The following high phase lasts 2N+2 or 2N+3 cycles, depending on the phase parity, and never less.
- R5: A reload value of 0 is treated as 1: low phases last 2 cycles and unstretched high phases last 4 cycles.
- R6: `roll_stb` is high for exactly one cycle, in the first cycle after each change of `scl_drive_low` caused by counter expiry. There are two strobes per SCL period.
- R7: When `en` drops during operation, `scl_drive_low` is 0 and `roll_stb` is 0 from the next cycle on.
- R8: The reload value is taken at each reload, so a new value governs every phase that starts after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables clock generation; when low the block is idle with SCL released |
| reload | input | 7 | Count length N of each SCL phase; 0 acts as 1 |
| scl_in | input | 1 | SCL line as seen on the pin (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 lets it float high |
| roll_stb | output | 1 | One-cycle pulse at every counter expiry |

## Verification
Most internal faults appear as a wrong phase length on `scl_drive_low` or on the line, no later than one phase (at most 2N+3 cycles) after the fault. This covers a counter that steps at the wrong rate, reloads the wrong value, or wraps instead of stopping. A wait condition that is not released, or is left too early, shows within one stretched low phase. In the first case SCL never goes low again. In the second the high phase comes out shorter than 2N+2 cycles. Strobe faults show up as a pulse count other than two per period, or as a pulse that is not aligned with a drive change.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                scl_in,
  output logic                scl_drive_low,
  output logic                roll_stb
);

  localparam logic [RELOAD_W-1:0] ONE  = RELOAD_W'(1);
  localparam logic [RELOAD_W-1:0] ZERO = '0;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_hi;
  logic [1:0]             phase;
  logic [RELOAD_W-1:0]    cnt;
  logic                   wait_hi;
  logic                   tick;
  logic                   expire;
  logic [RELOAD_W-1:0]    load_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};

  assign sync_hi  = sync_q[SYNC_STAGES-1];
  assign load_val = (reload == ZERO) ? ONE : reload;
  assign tick     = en && phase[0];
  assign expire   = tick && !wait_hi && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= 2'd0;
      cnt           <= ZERO;
      wait_hi       <= 1'b1;
      scl_drive_low <= 1'b0;
      roll_stb      <= 1'b0;
    end else if (!en) begin
      phase         <= 2'd0;
      cnt           <= ZERO;
      wait_hi       <= 1'b1;
      scl_drive_low <= 1'b0;
      roll_stb      <= 1'b0;
    end else begin
      phase    <= phase + 2'd1;
      roll_stb <= expire;
      if (wait_hi) begin
        if (sync_hi) begin
          cnt     <= load_val;
          wait_hi <= 1'b0;
        end
      end else if (tick) begin
        if (cnt == ONE) begin
          if (scl_drive_low) begin
            scl_drive_low <= 1'b0;
            wait_hi       <= 1'b1;
            cnt           <= ZERO;
          end else begin
            scl_drive_low <= 1'b1;
            cnt           <= load_val;
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         scl_drive_low,
  input logic         roll_stb,
  input logic         wait_hi,
  input logic         sync_hi,
  input logic [W-1:0] cnt
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !roll_stb)); // R7

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    roll_stb |=> !roll_stb); // R6

  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    roll_stb |-> (scl_drive_low != $past(scl_drive_low))); // R6

  AST_LOW_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> roll_stb); // R2

  AST_FROZEN_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_hi && !sync_hi) |=> $stable(cnt)); // R3

  AST_RELEASED_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hi |-> !scl_drive_low); // R3

  AST_NO_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_hi |-> (cnt != '0)); // R5

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.W(RELOAD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .scl_drive_low(scl_drive_low),
  .roll_stb     (roll_stb),
  .wait_hi      (wait_hi),
  .sync_hi      (sync_hi),
  .cnt          (cnt)
);

// File: tb/scl_clock_gen_test.sv
`timescale 1ns/1ps
module scl_clock_gen_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] reload = 7'd3;
  logic       scl_in;
  logic       scl_drive_low;
  logic       roll_stb;
  logic       force_low = 1'b0;
  int         stretch_cyc = 0;
  int         hold_cnt = 0;
  int         total = 0;
  int         bad = 0;

  always #(PERIOD/2) clk = ~clk;

  scl_clock_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .roll_stb(roll_stb)
  );

  always @(posedge clk)
    if (scl_drive_low) hold_cnt <= stretch_cyc;
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;

  assign scl_in = !(scl_drive_low || hold_cnt != 0 || force_low);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lo, output int st, output int hi, output int stb, output int stb_at_rise);
    do @(negedge clk); while (scl_drive_low);
    do @(negedge clk); while (!scl_drive_low);
    lo = 0; st = 0; hi = 0; stb = 0;
    stb_at_rise = roll_stb;
    while (scl_drive_low) begin lo++; stb += roll_stb; @(negedge clk); end
    while (!scl_in) begin st++; stb += roll_stb; @(negedge clk); end
    while (scl_in && !scl_drive_low) begin hi++; stb += roll_stb; @(negedge clk); end
  endtask

  task automatic t_reset_idle();
    int seen = 0;
    @(negedge clk);
    check("R1 drive after reset", scl_drive_low, 0);
    check("R1 stb after reset", roll_stb, 0);
    for (int i = 0; i < 20; i++) begin
      force_low = i[1];
      @(negedge clk);
      if (scl_drive_low || roll_stb) seen++;
    end
    force_low = 1'b0;
    check("R1 idle activity", seen, 0);
  endtask

  task automatic t_basic(input int n);
    int lo, st, hi, stb, sr;
    reload = 7'(n);
    en = 1'b1;
    measure(lo, st, hi, stb, sr);
    measure(lo, st, hi, stb, sr);
    check($sformatf("R2 low len N=%0d", n), lo, 2*n);
    check($sformatf("R3 stretch N=%0d", n), st, 0);
    check($sformatf("R3 high len N=%0d", n), hi, 2*n+2);
    check($sformatf("R6 strobes N=%0d", n), stb, 2);
    check($sformatf("R6 strobe at low start N=%0d", n), sr, 1);
  endtask

  task automatic t_zero();
    int lo, st, hi, stb, sr;
    reload = 7'd0;
    measure(lo, st, hi, stb, sr);
    measure(lo, st, hi, stb, sr);
    check("R5 low len reload 0", lo, 2);
    check("R5 high len reload 0", hi, 4);
  endtask

  task automatic t_stretch(input int n, input int h);
    int lo, st, hi, stb, sr;
    reload = 7'(n);
    stretch_cyc = h;
    measure(lo, st, hi, stb, sr);
    measure(lo, st, hi, stb, sr);
    stretch_cyc = 0;
    check($sformatf("R4 drive low N=%0d H=%0d", n, h), lo, 2*n);
    check($sformatf("R4 line held H=%0d", h), st, h);
    check($sformatf("R4 high min H=%0d", h), (hi >= 2*n+2) ? 1 : 0, 1);
    check($sformatf("R4 high max H=%0d", h), (hi <= 2*n+3) ? 1 : 0, 1);
    check($sformatf("R4 strobes H=%0d", h), stb, 2);
  endtask

  task automatic t_reload_change();
    int lo, st, hi, stb, sr;
    reload = 7'd4;
    measure(lo, st, hi, stb, sr);
    reload = 7'd6;
    measure(lo, st, hi, stb, sr);
    measure(lo, st, hi, stb, sr);
    check("R8 low after change", lo, 12);
    check("R8 high after change", hi, 14);
  endtask

  task automatic t_disable();
    int seen = 0;
    reload = 7'd5;
    do @(negedge clk); while (!scl_drive_low);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R7 drive after disable", scl_drive_low, 0);
    check("R7 stb after disable", roll_stb, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (scl_drive_low || roll_stb) seen++;
    end
    check("R7 quiet while disabled", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_basic(3);
    t_basic(5);
    t_basic(1);
    t_basic(127);
    t_zero();
    t_stretch(3, 9);
    t_stretch(3, 40);
    t_stretch(6, 4);
    t_reload_change();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD*150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule